// File: doc/BRIEF.md
# PLL Multiplier Configuration Encoder

This block turns a feedback multiplier N (12 bits) and a reference divider M (9 bits) into the four configuration bytes a fractional-N PLL expects. It also reports whether the pair means bypass or cannot be encoded. A client drives N, M and the reference frequency in kHz, then pulses `start`. Some time later the block raises `done` for one cycle. On that cycle `cfg_word`, `bypass` and `invalid` hold the result, and they keep it until the next completion.

Inside, one iterative shift-subtract divider, one quotient bit per cycle, is reused three times. The first division gives the integer ratio N/M, from which the prescale exponent P is taken. The second gives Q and R, the quotient and remainder of (N shifted left by P) divided by M. The third gives the VCO frequency Fin·N/M, from which a two-bit VCO band is picked.

The controller is a five-state machine. IDLE waits for `start` and latches the operands. From IDLE it goes to WRAP for a bypass pair, or to RATIO otherwise. RATIO moves to SCALE when its division ends. SCALE moves to VCO if Q and R are legal, or to WRAP if they are not. VCO moves to WRAP when its division ends. WRAP emits `done` and returns to IDLE.

Top module: `pll_mult_encoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `done`, `bypass` and `invalid` are 0 and `cfg_word` is 0.
- R2: If N = 0, M = 0 or N = M, the job completes with `bypass`=1 and `invalid`=0, and `cfg_word` keeps its previous value.
- R3: The ratio k is the integer quotient N/M. P is 0 when k ≥ 16. Otherwise P = 4 − floor(log2 k), taking P = 4 when k is 0 or 1.
- R4: With NN = N·2^P, Q = floor(NN/M) and R = NN mod M. If Q < 16, Q > 63 or R > 511, the job completes with `invalid`=1 and `bypass`=0, and `cfg_word` keeps its previous value.
- R5: A legal job completes with both flags 0 and writes `cfg_word` as follows. Bits [7:0] = N[11:4]. Bits [15:8] = {N[3:0], R[8:5]}. Bits [23:16] = {R[4:0], Q[5:3]}. Bits [31:24] = {Q[2:0], P[2:0], band[1:0]}.
- R6: The band is computed from V = floor(Fin_kHz·N/M). It is 3 when V ≥ 175000, 2 when V ≥ 150000, 1 when V ≥ 125000, and 0 otherwise.
- R7: A `start` pulse that arrives while a job is in progress is ignored. The result of the running job is not changed and no extra completion follows.
- R8: `done` is high for exactly one cycle per accepted job. `cfg_word` changes only on a cycle where `done` is high.
- R9: `bypass` and `invalid` are never high together. Both keep their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; sampled only when idle |
| n_in | input | 12 | Feedback multiplier N |
| m_in | input | 9 | Reference divider M |
| fin_khz | input | 20 | Reference frequency in kHz |
| cfg_word | output | 32 | Four packed configuration bytes, byte 0 in bits [7:0] |
| done | output | 1 | One-cycle completion pulse |
| bypass | output | 1 | Last job was a bypass pair |
| invalid | output | 1 | Last job had Q or R outside its legal range |

## Verification
The assertions assume that `start` is a single-cycle pulse and that the operands are stable in the cycle `start` is sampled. They also assume that reset is applied before the first job. The stimulus drives every input on the falling edge and raises `start` for exactly one cycle per job. It waits for `done` before offering the next accepted job. Its one deliberate exception is the extra pulse sent in the middle of a job to exercise R7.

// File: rtl/pllenc_pkg.sv
package pllenc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RATIO,
        S_SCALE,
        S_VCO,
        S_WRAP
    } enc_state_t;

    typedef enum logic [1:0] {
        V_WRITE,
        V_BYPASS,
        V_REJECT
    } verdict_t;

    localparam int unsigned BAND3_KHZ = 175000;
    localparam int unsigned BAND2_KHZ = 150000;
    localparam int unsigned BAND1_KHZ = 125000;
endpackage

// File: rtl/serial_divider.sv
module serial_divider #(
    parameter int DW = 32,
    parameter int VW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          busy,
    output logic          valid,
    output logic [DW-1:0] quotient,
    output logic [VW-1:0] remainder
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] quot_q;
    logic [VW-1:0] rem_q;
    logic [VW-1:0] dsr_q;
    logic [CW-1:0] cnt_q;
    logic [VW:0]   trial;
    logic [VW:0]   diff;
    logic          fits;

    assign trial = {rem_q, quot_q[DW-1]};
    assign diff  = trial - {1'b0, dsr_q};
    assign fits  = trial >= {1'b0, dsr_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            quot_q <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            busy   <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go && !busy) begin
                quot_q <= dividend;
                rem_q  <= '0;
                dsr_q  <= divisor;
                cnt_q  <= CW'(DW);
                busy   <= 1'b1;
            end else if (busy) begin
                quot_q <= {quot_q[DW-2:0], fits};
                rem_q  <= fits ? diff[VW-1:0] : trial[VW-1:0];
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy  <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quotient  = quot_q;
    assign remainder = rem_q;

    // R4: the remainder handed to the controller is always below the divisor
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        valid |-> (rem_q < dsr_q));
endmodule

// File: rtl/prescale_calc.sv
module prescale_calc #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] ratio,
    output logic [2:0]    p
);
    always_comb begin
        if (ratio >= DW'(16))     p = 3'd0;
        else if (ratio >= DW'(8)) p = 3'd1;
        else if (ratio >= DW'(4)) p = 3'd2;
        else if (ratio >= DW'(2)) p = 3'd3;
        else                      p = 3'd4;
    end
endmodule

// File: rtl/byte_packer.sv
module byte_packer (
    input  logic [11:0] n,
    input  logic [8:0]  r,
    input  logic [5:0]  q,
    input  logic [2:0]  p,
    input  logic [1:0]  band,
    output logic [31:0] word
);
    always_comb begin
        word[7:0]   = n[11:4];
        word[15:8]  = {n[3:0], r[8:5]};
        word[23:16] = {r[4:0], q[5:3]};
        word[31:24] = {q[2:0], p, band};
    end
endmodule

// File: rtl/pll_mult_encoder.sv
module pll_mult_encoder
    import pllenc_pkg::*;
#(
    parameter int N_W   = 12,
    parameter int M_W   = 9,
    parameter int F_W   = 20,
    parameter int Q_LO  = 16,
    parameter int Q_HI  = 63,
    parameter int R_MAX = 511
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N_W-1:0] n_in,
    input  logic [M_W-1:0] m_in,
    input  logic [F_W-1:0] fin_khz,
    output logic [31:0]    cfg_word,
    output logic           done,
    output logic           bypass,
    output logic           invalid
);
    localparam int DIV_W = F_W + N_W;

    enc_state_t     state_q, state_d;
    verdict_t       verdict_q;
    logic [N_W-1:0] n_q;
    logic [M_W-1:0] m_q;
    logic [F_W-1:0] f_q;
    logic [2:0]     p_q;
    logic [5:0]     q_q;
    logic [M_W-1:0] r_q;
    logic [1:0]     band_q;
    logic           launch_q;

    logic [DIV_W-1:0] div_dividend, div_quot;
    logic [M_W-1:0]   div_rem;
    logic             div_busy, div_valid;
    logic [2:0]       p_calc;
    logic [1:0]       band_calc;
    logic [31:0]      packed_word;
    logic             in_bypass, scale_ok;

    assign in_bypass = (n_in == '0) || (m_in == '0) || (n_in == N_W'(m_in));
    assign scale_ok  = (div_quot >= DIV_W'(Q_LO)) && (div_quot <= DIV_W'(Q_HI))
                       && (32'(div_rem) <= 32'(R_MAX));

    always_comb begin
        unique case (state_q)
            S_SCALE: div_dividend = DIV_W'(n_q) << p_q;
            S_VCO:   div_dividend = DIV_W'(f_q) * DIV_W'(n_q);
            default: div_dividend = DIV_W'(n_q);
        endcase
    end

    always_comb begin
        if (div_quot >= DIV_W'(BAND3_KHZ))      band_calc = 2'd3;
        else if (div_quot >= DIV_W'(BAND2_KHZ)) band_calc = 2'd2;
        else if (div_quot >= DIV_W'(BAND1_KHZ)) band_calc = 2'd1;
        else                                    band_calc = 2'd0;
    end

    serial_divider #(.DW(DIV_W), .VW(M_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .go        (launch_q),
        .dividend  (div_dividend),
        .divisor   (m_q),
        .busy      (div_busy),
        .valid     (div_valid),
        .quotient  (div_quot),
        .remainder (div_rem)
    );

    prescale_calc #(.DW(DIV_W)) u_pre (
        .ratio (div_quot),
        .p     (p_calc)
    );

    byte_packer u_pack (
        .n    (n_q),
        .r    (r_q),
        .q    (q_q),
        .p    (p_q),
        .band (band_q),
        .word (packed_word)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)     state_d = in_bypass ? S_WRAP : S_RATIO;
            S_RATIO: if (div_valid) state_d = S_SCALE;
            S_SCALE: if (div_valid) state_d = scale_ok ? S_VCO : S_WRAP;
            S_VCO:   if (div_valid) state_d = S_WRAP;
            S_WRAP:                 state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= V_WRITE;
            n_q       <= '0;
            m_q       <= '0;
            f_q       <= '0;
            p_q       <= '0;
            q_q       <= '0;
            r_q       <= '0;
            band_q    <= '0;
            launch_q  <= 1'b0;
            cfg_word  <= '0;
            done      <= 1'b0;
            bypass    <= 1'b0;
            invalid   <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            done     <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    n_q <= n_in;
                    m_q <= m_in;
                    f_q <= fin_khz;
                    if (in_bypass) begin
                        verdict_q <= V_BYPASS;
                    end else begin
                        verdict_q <= V_WRITE;
                        launch_q  <= 1'b1;
                    end
                end
                S_RATIO: if (div_valid) begin
                    p_q      <= p_calc;
                    launch_q <= 1'b1;
                end
                S_SCALE: if (div_valid) begin
                    q_q <= div_quot[5:0];
                    r_q <= div_rem;
                    if (scale_ok) launch_q  <= 1'b1;
                    else          verdict_q <= V_REJECT;
                end
                S_VCO: if (div_valid) band_q <= band_calc;
                S_WRAP: begin
                    done    <= 1'b1;
                    bypass  <= (verdict_q == V_BYPASS);
                    invalid <= (verdict_q == V_REJECT);
                    if (verdict_q == V_WRITE) cfg_word <= packed_word;
                end
                default: ;
            endcase
        end
    end

    // R8: completion pulse never lasts two cycles
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: configuration word only moves together with done
    a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cfg_word));
    // R9: flags are mutually exclusive
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bypass && invalid));
    // R4: a committed word carries a Q field inside its legal window
    a_r4_q_field_legal: assert property (@(posedge clk) disable iff (rst)
        (done && !bypass && !invalid) |->
        ({cfg_word[18:16], cfg_word[31:29]} >= 6'(Q_LO)));
    // R3: a committed P field never exceeds 4
    a_r3_p_field_max: assert property (@(posedge clk) disable iff (rst)
        (done && !bypass && !invalid) |-> (cfg_word[28:26] <= 3'd4));
    // R7: operands latched for a job do not move while the job runs
    a_r7_operands_held: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |=> $stable(n_q) && $stable(m_q) && $stable(f_q));
    // R7: the divider is never asked to start while it is still working
    a_r7_no_relaunch: assert property (@(posedge clk) disable iff (rst)
        launch_q |-> !div_busy);
endmodule

// File: tb/pll_mult_encoder_test.sv
module pll_mult_encoder_test;
    typedef struct packed {
        logic [31:0] word;
        logic        byp;
        logic        inv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] n_in = '0;
    logic [8:0]  m_in = '0;
    logic [19:0] fin_khz = '0;
    logic [31:0] cfg_word;
    logic        done, bypass, invalid;

    int checks = 0;
    int fails = 0;
    int dones = 0;
    int cycles = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [31:0] model_word = '0;
    logic [31:0] last_word = '0;
    logic        last_byp = 1'b0, last_inv = 1'b0, prev_done = 1'b0;

    always #2.5 clk = ~clk;

    pll_mult_encoder uut (
        .clk(clk), .rst(rst), .start(start), .n_in(n_in), .m_in(m_in),
        .fin_khz(fin_khz), .cfg_word(cfg_word), .done(done),
        .bypass(bypass), .invalid(invalid)
    );

    function automatic exp_t model(input int n, input int m, input longint f);
        exp_t e;
        int k, p, nn, q, r, band;
        longint v;
        e.word = model_word; e.byp = 1'b0; e.inv = 1'b0;
        if (n == 0 || m == 0 || n == m) begin
            e.byp = 1'b1; return e;                 // R2
        end
        k = n / m;                                  // R3
        if (k >= 16) p = 0;
        else begin
            p = 4;
            while (k > 1) begin k = k >> 1; p = p - 1; end
        end
        nn = n << p; q = nn / m; r = nn % m;         // R4
        if (q < 16 || q > 63 || r > 511) begin
            e.inv = 1'b1; return e;
        end
        v = (f * longint'(n)) / longint'(m);         // R6
        band = (v >= 175000) ? 3 : (v >= 150000) ? 2 : (v >= 125000) ? 1 : 0;
        e.word[7:0]   = 8'(n >> 4);                  // R5
        e.word[15:8]  = {4'(n), 4'(r >> 5)};
        e.word[23:16] = {5'(r), 3'(q >> 3)};
        e.word[31:24] = {3'(q), 3'(p), 2'(band)};
        return e;
    endfunction

    task automatic run_job(input int n, input int m, input int f, input string tag);
        exp_t e;
        int target;
        e = model(n, m, longint'(f));
        if (!e.byp && !e.inv) model_word = e.word;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        target = dones + 1;
        @(negedge clk);
        n_in = 12'(n); m_in = 9'(m); fin_khz = 20'(f); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (dones >= target);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                dones = dones + 1;
                checks = checks + 1;
                if (exp_q.size() == 0) begin
                    fails = fails + 1;
                    $display("FAIL R7 unexpected completion: actual word=%h expected none", cfg_word);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cfg_word !== e.word || bypass !== e.byp || invalid !== e.inv) begin
                        fails = fails + 1;
                        $display("FAIL %s: actual word=%h byp=%b inv=%b expected word=%h byp=%b inv=%b",
                                 t, cfg_word, bypass, invalid, e.word, e.byp, e.inv);
                    end
                end
                if (prev_done) begin
                    fails = fails + 1;
                    $display("FAIL R8 done high two cycles: actual 1 expected 0");
                end
            end else if (cfg_word !== last_word || bypass !== last_byp || invalid !== last_inv) begin
                checks = checks + 1;
                fails = fails + 1;
                $display("FAIL R8/R9 outputs moved without done: actual %h/%b/%b expected %h/%b/%b",
                         cfg_word, bypass, invalid, last_word, last_byp, last_inv);
            end
            last_word = cfg_word; last_byp = bypass; last_inv = invalid;
            prev_done = done;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks = checks + 1;
        if (cfg_word !== 32'h0 || done !== 1'b0 || bypass !== 1'b0 || invalid !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R1 reset: actual %h/%b/%b/%b expected 0/0/0/0", cfg_word, done, bypass, invalid);
        end
        rst = 1'b0;
        @(negedge clk);
        checks = checks + 1;
        if (cfg_word !== 32'h0 || done !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R1 after reset: actual %h/%b expected 0/0", cfg_word, done);
        end

        run_job(100, 3, 25000, "R5 ratio>=16");
        run_job(50, 7, 10000, "R3 p=2");
        run_job(31, 30, 4000, "R3 ratio=1 q=16");
        run_job(4095, 65, 2000, "R4 q=63 edge");
        run_job(4095, 511, 20000, "R5 max n and m");
        // R6 band thresholds
        run_job(5, 1, 24999, "R6 band0 below");
        run_job(5, 1, 25000, "R6 band1 edge");
        run_job(5, 1, 29999, "R6 band1 below2");
        run_job(5, 1, 30000, "R6 band2 edge");
        run_job(5, 1, 35000, "R6 band3 edge");
        // R2 bypass pairs keep previous word
        run_job(0, 5, 25000, "R2 n zero");
        run_job(7, 0, 25000, "R2 m zero");
        run_job(9, 9, 25000, "R2 n equals m");
        // R4 illegal pairs keep previous word
        run_job(4095, 1, 25000, "R4 q too high");
        run_job(64, 1, 25000, "R4 q=64");
        run_job(30, 31, 25000, "R4 q=15");
        run_job(1, 511, 25000, "R4 q zero");
        run_job(100, 3, 25000, "R9 flags clear after reject");

        // R7: second start during a job is ignored
        begin
            exp_t e;
            int target;
            e = model(50, 7, 64'd30000);
            model_word = e.word;
            exp_q.push_back(e);
            tag_q.push_back("R7 start while busy");
            target = dones + 1;
            @(negedge clk);
            n_in = 12'd50; m_in = 9'd7; fin_khz = 20'd30000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            n_in = 12'd0; m_in = 9'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait (dones >= target);
            repeat (150) @(negedge clk);
            checks = checks + 1;
            if (dones != target) begin
                fails = fails + 1;
                $display("FAIL R7 extra completions: actual %0d expected %0d", dones, target);
            end
        end

        checks = checks + 1;
        if (exp_q.size() != 0) begin
            fails = fails + 1;
            $display("FAIL R8 missing completions: actual %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule